// File: doc/BRIEF.md
# External Bus Arbitration Controller

This block decides who drives a processor's external address, data and strobe bus: the processor, or one other bus master such as a second processor or a DMA engine. A mode-register bit picks one of two roles. In slave mode the processor owns the bus by default, and an outside device asks for it on the request pin; the block then grants it. In master mode the request pin turns into an output and the grant pin into an input, and the processor has to ask for the bus before each use.

The core side uses a simple handshake. `core_ext_req` marks a wanted external access, and `core_wait` inserts wait states until the bus may be used. `rmw_lock` marks a read-modify-write sequence that a request must not split. The block drives the tri-state enables of the bus pins, and it drives or releases the shared bus-busy line. All three incoming pins pass through a synchronizer before any decision uses them.

States. Slave side:
- SL_OWN: the processor owns and drives the bus.
- SL_DELAY: grant countdown.
- SL_RELEASE: the drivers are off and the grant is not yet given.
- SL_GRANT: the grant is asserted.
- SL_RECLAIM: the grant is withdrawn and the block waits for bus-busy to clear.

Master side:
- MS_IDLE: the block neither owns nor asks for the bus.
- MS_REQ: the request is asserted and the block waits for the grant.
- MS_OWN: the block drives the bus.
- MS_DROP: the drivers are off while the request is still held.

Transitions:
- SL_OWN to SL_DELAY or SL_RELEASE on an unlocked outside request.
- SL_DELAY back to SL_OWN when the request drops or the lock rises.
- SL_DELAY to SL_RELEASE when the count ends.
- SL_RELEASE to SL_GRANT always.
- SL_GRANT to SL_RECLAIM when the request drops.
- SL_RECLAIM to SL_OWN when bus-busy clears.
- SL_OWN to MS_IDLE, and MS_IDLE to SL_OWN, on a mode change while idle.
- MS_IDLE to MS_REQ on a core access.
- MS_REQ back to MS_IDLE when the core access is withdrawn.
- MS_REQ to MS_OWN when the grant is present and bus-busy is clear.
- MS_OWN to MS_DROP when the access ends and the lock is clear.
- MS_DROP to MS_IDLE always.

Top module: `ext_bus_arbiter`

## Requirements
- R1: After reset the block is in slave mode and owns the bus. The request pin is an input (`req_oe`=0), the grant pin is an output (`gnt_oe`=1) held high, `bus_oe`=1, and `bb_oe`=1 with `bb_out_n`=1.
- R2: In slave mode, when `req_in_n` goes low and the lock is clear, `gnt_out_n` goes low exactly GNT_DLY+2 clock cycles later. Of these, 2 cycles are synchronizer delay and GNT_DLY cycles are counted from the synchronized edge.
- R3: `bus_oe` and `bb_oe` fall exactly one cycle before `gnt_out_n` falls, and both stay low for as long as the grant is asserted.
- R4: In slave mode, a core access wait-states (`core_wait`=1) from the second cycle after `req_in_n` falls. It stays stalled until the request has been withdrawn and the synchronized bus-busy is high. `core_wait` falls 3 cycles after `bb_in_n` rises.
- R5: While `rmw_lock` is high and the block drives the bus, the bus stays driven and no grant is given; a core access is not stalled. Once the lock drops with a request pending, the grant follows GNT_DLY cycles later.
- R6: In master mode (`mode_master`=1, taken one cycle after being set while idle) the request pin is an output (`req_oe`=1), the grant pin is an input (`gnt_oe`=0), and the bus is not driven until granted.
- R7: In master mode, a core access drives `req_out_n` low on the next cycle and is stalled until the grant pin is low and bus-busy is high. It proceeds, with `bus_oe`=1, 3 cycles after the last of these two conditions is met at the pins.
- R8: On a master-mode release, `bus_oe` drops one cycle before `req_out_n` returns high. The release comes when the core access has ended and the lock is clear.
- R9: With `core_ext_req` low, `core_wait` is low in every state, so internal-only work runs even while another master owns the bus. While a core access proceeds, `bb_out_n` is driven low.
- R10: A mode change takes effect only while there is no core access and no lock. A pending access in master mode keeps the block in master mode with its request asserted.
- R11: After a slave-mode grant, raising `req_in_n` raises `gnt_out_n` 3 cycles later. The bus, `bus_oe` and `bb_oe`, is taken back one cycle after the synchronized bus-busy reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_master | input | 1 | Mode-register bit: 1 selects master mode |
| req_in_n | input | 1 | Request pin as sensed, active low |
| req_out_n | output | 1 | Request pin drive value, active low |
| req_oe | output | 1 | Request pin output enable (master mode) |
| gnt_in_n | input | 1 | Grant pin as sensed, active low |
| gnt_out_n | output | 1 | Grant pin drive value, active low |
| gnt_oe | output | 1 | Grant pin output enable (slave mode) |
| bb_in_n | input | 1 | Bus-busy pin as sensed, active low |
| bb_out_n | output | 1 | Bus-busy drive value, active low |
| bb_oe | output | 1 | Bus-busy output enable |
| core_ext_req | input | 1 | Core wants an external bus access |
| core_wait | output | 1 | Insert wait states into the core access |
| rmw_lock | input | 1 | Read-modify-write sequence in progress |
| bus_oe | output | 1 | Tri-state enable for address, data and strobe pins |

## Verification
The grant path is driven four ways:
- A plain outside request against an idle core, which pins down the synchronizer and grant count.
- A request that arrives while the core is stalled and the other master holds bus-busy low, which separates "request withdrawn" from "bus actually free" as the release condition.
- A request that overlaps a locked read-modify-write, which shows that the lock holds off the grant rather than the core.
- Master-mode accesses with the grant delayed, and with the grant present but bus-busy still low, which tell the grant condition apart from the busy condition.

A mode change is also tried with an access pending, to show that the change is deferred.

// File: rtl/ext_bus_arbiter_pkg.sv
`timescale 1ns/1ps
package ext_bus_arbiter_pkg;

    typedef enum logic [3:0] {
        SL_OWN     = 4'd0,
        SL_DELAY   = 4'd1,
        SL_RELEASE = 4'd2,
        SL_GRANT   = 4'd3,
        SL_RECLAIM = 4'd4,
        MS_IDLE    = 4'd5,
        MS_REQ     = 4'd6,
        MS_OWN     = 4'd7,
        MS_DROP    = 4'd8
    } arb_state_t;

    typedef struct packed {
        logic bus_oe;
        logic bb_oe;
        logic bb_out_n;
        logic req_oe;
        logic req_out_n;
        logic gnt_oe;
        logic gnt_out_n;
        logic core_wait;
    } arb_pins_t;

    localparam arb_pins_t PINS_IDLE = '{
        bus_oe: 1'b0, bb_oe: 1'b0, bb_out_n: 1'b1, req_oe: 1'b0,
        req_out_n: 1'b1, gnt_oe: 1'b1, gnt_out_n: 1'b1, core_wait: 1'b0
    };

endpackage

// File: rtl/ext_bus_arbiter_sync.sv
`timescale 1ns/1ps
module ext_bus_arbiter_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ext_bus_arbiter_delay.sv
`timescale 1ns/1ps
module ext_bus_arbiter_delay #(
    parameter int LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);

    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (start)            cnt_q <= '0;
        else if (run && !expired)  cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LAST);

endmodule

// File: rtl/ext_bus_arbiter_fsm.sv
`timescale 1ns/1ps
module ext_bus_arbiter_fsm
    import ext_bus_arbiter_pkg::*;
#(
    parameter int DLY_CYC = 0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_master,
    input  logic      req_s,
    input  logic      gnt_s,
    input  logic      bb_s,
    input  logic      core_ext_req,
    input  logic      rmw_lock,
    input  logic      dly_expired,
    output logic      dly_start,
    output logic      dly_run,
    output arb_pins_t pins
);

    localparam arb_state_t GRANT_PATH = (DLY_CYC > 0) ? SL_DELAY : SL_RELEASE;

    arb_state_t state_q;
    arb_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SL_OWN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_OWN: begin
                if (mode_master && !req_s && !core_ext_req && !rmw_lock)
                    state_d = MS_IDLE;
                else if (req_s && !rmw_lock)
                    state_d = GRANT_PATH;
            end
            SL_DELAY: begin
                if (!req_s || rmw_lock) state_d = SL_OWN;
                else if (dly_expired)   state_d = SL_RELEASE;
            end
            SL_RELEASE: state_d = SL_GRANT;
            SL_GRANT: begin
                if (!req_s) state_d = SL_RECLAIM;
            end
            SL_RECLAIM: begin
                if (!bb_s) state_d = SL_OWN;
            end
            MS_IDLE: begin
                if (core_ext_req)                    state_d = MS_REQ;
                else if (!mode_master && !rmw_lock)  state_d = SL_OWN;
            end
            MS_REQ: begin
                if (!core_ext_req)       state_d = MS_IDLE;
                else if (gnt_s && !bb_s) state_d = MS_OWN;
            end
            MS_OWN: begin
                if (!core_ext_req && !rmw_lock) state_d = MS_DROP;
            end
            MS_DROP: state_d = MS_IDLE;
            default: state_d = SL_OWN;
        endcase
    end

    assign dly_start = (state_q == SL_OWN);
    assign dly_run   = (state_q == SL_DELAY);

    // outputs
    always_comb begin
        pins           = PINS_IDLE;
        pins.core_wait = core_ext_req;
        unique case (state_q)
            SL_OWN, SL_DELAY: begin
                pins.bus_oe    = 1'b1;
                pins.bb_oe     = 1'b1;
                if (state_q == SL_OWN)
                    pins.core_wait = core_ext_req && req_s && !rmw_lock;
                else
                    pins.core_wait = core_ext_req && !rmw_lock;
                pins.bb_out_n  = !((core_ext_req && !pins.core_wait) || rmw_lock);
            end
            SL_RELEASE, SL_RECLAIM: begin
                pins.gnt_out_n = 1'b1;
            end
            SL_GRANT: begin
                pins.gnt_out_n = 1'b0;
            end
            MS_IDLE: begin
                pins.req_oe = 1'b1;
                pins.gnt_oe = 1'b0;
            end
            MS_REQ, MS_DROP: begin
                pins.req_oe    = 1'b1;
                pins.gnt_oe    = 1'b0;
                pins.req_out_n = 1'b0;
            end
            MS_OWN: begin
                pins.req_oe    = 1'b1;
                pins.gnt_oe    = 1'b0;
                pins.req_out_n = 1'b0;
                pins.bus_oe    = 1'b1;
                pins.bb_oe     = 1'b1;
                pins.core_wait = 1'b0;
                pins.bb_out_n  = !(core_ext_req || rmw_lock);
            end
            default: pins = PINS_IDLE;
        endcase
    end

endmodule

// File: rtl/ext_bus_arbiter.sv
`timescale 1ns/1ps
module ext_bus_arbiter
    import ext_bus_arbiter_pkg::*;
#(
    parameter int GNT_DLY     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_master,
    input  logic req_in_n,
    output logic req_out_n,
    output logic req_oe,
    input  logic gnt_in_n,
    output logic gnt_out_n,
    output logic gnt_oe,
    input  logic bb_in_n,
    output logic bb_out_n,
    output logic bb_oe,
    input  logic core_ext_req,
    output logic core_wait,
    input  logic rmw_lock,
    output logic bus_oe
);

    localparam int DLY_CYC   = (GNT_DLY > 2) ? GNT_DLY - 2 : 0;
    localparam int CNT_LIMIT = (DLY_CYC > 0) ? DLY_CYC : 1;

    logic [2:0] pins_raw;
    logic [2:0] pins_sync;
    logic       req_s, gnt_s, bb_s;
    logic       dly_start, dly_run, dly_expired;
    arb_pins_t  pins;

    assign pins_raw = {bb_in_n, gnt_in_n, req_in_n};

    ext_bus_arbiter_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b111)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_sync)
    );

    assign req_s = !pins_sync[0];
    assign gnt_s = !pins_sync[1];
    assign bb_s  = !pins_sync[2];

    ext_bus_arbiter_delay #(
        .LIMIT (CNT_LIMIT)
    ) i_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (dly_start),
        .run     (dly_run),
        .expired (dly_expired)
    );

    ext_bus_arbiter_fsm #(
        .DLY_CYC (DLY_CYC)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_master  (mode_master),
        .req_s        (req_s),
        .gnt_s        (gnt_s),
        .bb_s         (bb_s),
        .core_ext_req (core_ext_req),
        .rmw_lock     (rmw_lock),
        .dly_expired  (dly_expired),
        .dly_start    (dly_start),
        .dly_run      (dly_run),
        .pins         (pins)
    );

    assign bus_oe    = pins.bus_oe;
    assign bb_oe     = pins.bb_oe;
    assign bb_out_n  = pins.bb_out_n;
    assign req_oe    = pins.req_oe;
    assign req_out_n = pins.req_out_n;
    assign gnt_oe    = pins.gnt_oe;
    assign gnt_out_n = pins.gnt_out_n;
    assign core_wait = pins.core_wait;

endmodule

// File: rtl/ext_bus_arbiter_chk.sv
`timescale 1ns/1ps
module ext_bus_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic core_ext_req,
    input logic rmw_lock,
    input logic core_wait,
    input logic bus_oe,
    input logic bb_oe,
    input logic req_oe,
    input logic req_out_n,
    input logic gnt_oe,
    input logic gnt_out_n
);

    AST_GRANT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_oe && !gnt_out_n) |-> (!bus_oe && !bb_oe)); // R3

    AST_OFF_BEFORE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gnt_out_n) |-> $past(!bus_oe)); // R3

    AST_LOCK_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_lock && bus_oe) |=> bus_oe); // R5

    AST_NO_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ext_req |-> !core_wait); // R9

    AST_PROCEED_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ext_req && !core_wait) |-> bus_oe); // R4

    AST_PIN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({req_oe, gnt_oe})); // R6

    AST_REQ_WHILE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_oe && bus_oe) |-> !req_out_n); // R8

    AST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req_oe) |-> $past(!core_ext_req && !rmw_lock)); // R10

endmodule

bind ext_bus_arbiter ext_bus_arbiter_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_ext_req (core_ext_req),
    .rmw_lock     (rmw_lock),
    .core_wait    (core_wait),
    .bus_oe       (bus_oe),
    .bb_oe        (bb_oe),
    .req_oe       (req_oe),
    .req_out_n    (req_out_n),
    .gnt_oe       (gnt_oe),
    .gnt_out_n    (gnt_out_n)
);

// File: tb/test_ext_bus_arbiter.sv
`timescale 1ns/1ps
module test_ext_bus_arbiter;

    localparam int G = 2;

    typedef enum int { S_GNT, S_BUSOE, S_WAIT, S_REQOUT, S_BBOE, S_BBOUT, S_GNTOE, S_REQOE } sig_e;
    typedef struct {
        int    cyc;
        sig_e  sig;
        logic  val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_master = 1'b0;
    logic core_ext_req = 1'b0;
    logic rmw_lock = 1'b0;
    logic ext_req_n = 1'b1, ext_gnt_n = 1'b1, ext_bb_n = 1'b1;
    logic req_in_n, req_out_n, req_oe, gnt_in_n, gnt_out_n, gnt_oe;
    logic bb_in_n, bb_out_n, bb_oe, core_wait, bus_oe;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign req_in_n = req_oe ? req_out_n : ext_req_n;
    assign gnt_in_n = gnt_oe ? gnt_out_n : ext_gnt_n;
    assign bb_in_n  = bb_oe  ? bb_out_n  : ext_bb_n;

    ext_bus_arbiter #(.GNT_DLY(G)) i_ext_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
        .req_in_n(req_in_n), .req_out_n(req_out_n), .req_oe(req_oe),
        .gnt_in_n(gnt_in_n), .gnt_out_n(gnt_out_n), .gnt_oe(gnt_oe),
        .bb_in_n(bb_in_n), .bb_out_n(bb_out_n), .bb_oe(bb_oe),
        .core_ext_req(core_ext_req), .core_wait(core_wait),
        .rmw_lock(rmw_lock), .bus_oe(bus_oe)
    );

    function automatic logic get_sig(sig_e s);
        case (s)
            S_GNT:    return gnt_out_n;
            S_BUSOE:  return bus_oe;
            S_WAIT:   return core_wait;
            S_REQOUT: return req_out_n;
            S_BBOE:   return bb_oe;
            S_BBOUT:  return bb_out_n;
            S_GNTOE:  return gnt_oe;
            default:  return req_oe;
        endcase
    endfunction

    // driver side: push an expectation at an absolute cycle
    task automatic expect_at(int c, sig_e s, logic v, string tag);
        exp_t e;
        e.cyc = c; e.sig = s; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare the items due this cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc <= cyc) begin
                    logic act;
                    act = get_sig(sb[i].sig);
                    n_checks++;
                    if (act !== sb[i].val) begin
                        n_fail++;
                        $display("FAIL %s cycle %0d %s: actual %b expected %b",
                                 sb[i].tag, sb[i].cyc, sb[i].sig.name(), act, sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n, m, p, k, a, b, c, d, e, f, g, h;
        tick(4);
        rst_n = 1'b1;
        n = cyc;
        // R1: reset state
        expect_at(n, S_BUSOE, 1'b1, "R1");
        expect_at(n, S_REQOE, 1'b0, "R1");
        expect_at(n, S_GNTOE, 1'b1, "R1");
        expect_at(n, S_GNT,   1'b1, "R1");
        expect_at(n, S_BBOE,  1'b1, "R1");
        expect_at(n, S_BBOUT, 1'b1, "R1");
        tick(2);
        // R9: access with no request proceeds and drives bus-busy
        n = cyc;
        core_ext_req = 1'b1;
        expect_at(n, S_WAIT,  1'b0, "R9");
        expect_at(n, S_BBOUT, 1'b0, "R9");
        tick(1);
        core_ext_req = 1'b0;
        tick(2);

        // R2/R3: slave grant against an idle core
        n = cyc;
        ext_req_n = 1'b0;
        expect_at(n + G,     S_BUSOE, 1'b1, "R3");
        expect_at(n + G + 1, S_BUSOE, 1'b0, "R3");
        expect_at(n + G + 1, S_GNT,   1'b1, "R2");
        expect_at(n + G + 2, S_GNT,   1'b0, "R2");
        expect_at(n + G + 2, S_BBOE,  1'b0, "R3");
        expect_at(n + G + 2, S_WAIT,  1'b0, "R9");
        tick(G + 4);
        // R4: core stalls while the other master owns the bus
        a = cyc;
        core_ext_req = 1'b1;
        ext_bb_n = 1'b0;
        expect_at(a, S_WAIT, 1'b1, "R4");
        tick(2);
        m = cyc;
        ext_req_n = 1'b1;
        expect_at(m + 2, S_GNT,   1'b0, "R11");
        expect_at(m + 3, S_GNT,   1'b1, "R11");
        expect_at(m + 5, S_BUSOE, 1'b0, "R4");
        expect_at(m + 5, S_WAIT,  1'b1, "R4");
        tick(6);
        p = cyc;
        ext_bb_n = 1'b1;
        expect_at(p + 2, S_WAIT,  1'b1, "R4");
        expect_at(p + 3, S_WAIT,  1'b0, "R4");
        expect_at(p + 3, S_BUSOE, 1'b1, "R11");
        expect_at(p + 3, S_BBOE,  1'b1, "R11");
        tick(5);
        core_ext_req = 1'b0;
        tick(2);

        // R5: locked read-modify-write holds off the grant
        n = cyc;
        rmw_lock = 1'b1;
        core_ext_req = 1'b1;
        ext_req_n = 1'b0;
        expect_at(n + 2,     S_WAIT,  1'b0, "R5");
        expect_at(n + G + 3, S_GNT,   1'b1, "R5");
        expect_at(n + 6,     S_BUSOE, 1'b1, "R5");
        expect_at(n + 6,     S_WAIT,  1'b0, "R5");
        tick(7);
        k = cyc;
        rmw_lock = 1'b0;
        core_ext_req = 1'b0;
        expect_at(k + G - 1, S_BUSOE, 1'b0, "R5");
        expect_at(k + G - 1, S_GNT,   1'b1, "R5");
        expect_at(k + G,     S_GNT,   1'b0, "R5");
        expect_at(k + G + 1, S_WAIT,  1'b0, "R9");
        tick(G + 3);
        m = cyc;
        ext_req_n = 1'b1;
        expect_at(m + 3, S_GNT,   1'b1, "R11");
        expect_at(m + 4, S_BUSOE, 1'b1, "R11");
        tick(6);

        // R6: switch to master mode
        n = cyc;
        mode_master = 1'b1;
        expect_at(n + 1, S_REQOE,  1'b1, "R6");
        expect_at(n + 1, S_GNTOE,  1'b0, "R6");
        expect_at(n + 1, S_BUSOE,  1'b0, "R6");
        expect_at(n + 1, S_REQOUT, 1'b1, "R6");
        tick(3);
        // R7: request and wait for the grant
        a = cyc;
        core_ext_req = 1'b1;
        expect_at(a,     S_WAIT,   1'b1, "R7");
        expect_at(a + 1, S_REQOUT, 1'b0, "R7");
        expect_at(a + 5, S_WAIT,   1'b1, "R7");
        expect_at(a + 5, S_BUSOE,  1'b0, "R7");
        tick(6);
        b = cyc;
        ext_gnt_n = 1'b0;
        expect_at(b + 2, S_WAIT,  1'b1, "R7");
        expect_at(b + 3, S_WAIT,  1'b0, "R7");
        expect_at(b + 3, S_BUSOE, 1'b1, "R7");
        expect_at(b + 3, S_BBOE,  1'b1, "R7");
        tick(5);
        // R5 in master mode: lock keeps the bus after the access ends
        c = cyc;
        rmw_lock = 1'b1;
        core_ext_req = 1'b0;
        expect_at(c + 2, S_BUSOE, 1'b1, "R5");
        tick(3);
        // R8: release order
        d = cyc;
        rmw_lock = 1'b0;
        expect_at(d + 1, S_BUSOE,  1'b0, "R8");
        expect_at(d + 1, S_REQOUT, 1'b0, "R8");
        expect_at(d + 2, S_REQOUT, 1'b1, "R8");
        tick(3);
        ext_gnt_n = 1'b1;
        tick(3);

        // R7: grant present but bus-busy still held by the other master
        e = cyc;
        ext_bb_n = 1'b0;
        ext_gnt_n = 1'b0;
        core_ext_req = 1'b1;
        expect_at(e + 5, S_WAIT, 1'b1, "R7");
        tick(6);
        f = cyc;
        ext_bb_n = 1'b1;
        expect_at(f + 2, S_WAIT, 1'b1, "R7");
        expect_at(f + 3, S_WAIT, 1'b0, "R7");
        tick(4);
        core_ext_req = 1'b0;
        tick(3);
        ext_gnt_n = 1'b1;
        tick(3);

        // R10: mode change deferred while an access is pending
        g = cyc;
        core_ext_req = 1'b1;
        mode_master = 1'b0;
        expect_at(g + 1, S_REQOE,  1'b1, "R10");
        expect_at(g + 1, S_REQOUT, 1'b0, "R10");
        tick(3);
        h = cyc;
        core_ext_req = 1'b0;
        expect_at(h + 1, S_REQOUT, 1'b1, "R10");
        expect_at(h + 2, S_REQOE,  1'b0, "R10");
        expect_at(h + 2, S_GNTOE,  1'b1, "R10");
        expect_at(h + 2, S_BUSOE,  1'b1, "R10");
        tick(5);

        if (sb.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule